// File: doc/BRIEF.md
# Flag-Driven Branch Resolver

This unit holds the four processor status flags (carry, negative, overflow, zero) produced by an add or subtract. It decides from a 4-bit condition selector whether a branch goes. An add or subtract presented with the update strobe runs through an internal arithmetic stage. Only the resulting flags are captured; the arithmetic result itself is discarded, which is exactly what a compare instruction needs.

A branch request reads the flags currently held and resolves in the same cycle. The outputs are a taken indication and the next program counter. That counter is the supplied target address when the branch goes, and the current address plus the instruction length otherwise. Besides the eight single-flag tests, the selector offers unsigned ordering (carry read as a borrow) and signed ordering (negative combined with overflow).

Top module: `brcond_unit`

## Requirements
- R1: While reset is asserted and just after it, the held flags are all zero, and with no branch request `br_taken` is 0 and `next_pc` is `pc_cur + instr_len`.
- R2: With `flag_upd`=1 and `op_sub`=1, the next clock loads flags from `opnd_a - opnd_b`: C=1 exactly when `opnd_a < opnd_b` unsigned (a borrow), Z=1 when the difference is zero, N equals the difference's top bit, and V=1 on signed overflow. The flags port packs them as bit 3 N, bit 2 Z, bit 1 V, bit 0 C. No result is kept.
- R3: With `flag_upd`=1 and `op_sub`=0, the flags come from `opnd_a + opnd_b`: C is the carry out, V=1 when both operands share a sign that differs from the sum's sign, and N and Z are as in R2.
- R4: With `flag_upd`=0, the held flags do not change.
- R5: Codes 0 to 7 test one flag each: 0 Z=1 (also "equal"), 1 Z=0 (also "not equal"), 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R6: Unsigned codes: 8 higher (C=0 and Z=0), 9 higher-or-same (C=0), 10 lower (C=1), 11 lower-or-same (C=1 or Z=1).
- R7: Signed codes: 12 greater (N xor V = 0 and Z=0), 13 greater-or-equal (N xor V = 0), 14 less (N xor V = 1), 15 less-or-equal (N xor V = 1 or Z=1).
- R8: When a requested branch's condition holds, `br_taken`=1 and `next_pc` equals `eff_addr`. Otherwise `next_pc` is `pc_cur + instr_len` modulo 2^AW.
- R9: With `br_valid`=0, `br_taken` is 0 whatever the flags and code.
- R10: When a flag update and a branch request occur in the same cycle, the branch resolves on the flags held before that clock edge; the new flags govern from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_upd | input | 1 | Load flags from this cycle's add/subtract |
| op_sub | input | 1 | 1 subtract/compare, 0 add |
| opnd_a | input | DW | First operand |
| opnd_b | input | DW | Second operand |
| br_valid | input | 1 | Branch request this cycle |
| br_cond | input | 4 | Condition selector |
| pc_cur | input | AW | Address of the current instruction |
| instr_len | input | LW | Length of the current instruction |
| eff_addr | input | AW | Branch target |
| br_taken | output | 1 | Branch goes |
| next_pc | output | AW | Next program counter |
| flags | output | 4 | Held flags {N,Z,V,C} |

## Verification
Two functions can fall in the same cycle: a flag update and a branch resolution. The bench provokes this both in directed steps and in a random mix, asserting `flag_upd` and `br_valid` together and choosing operands whose new flags would flip the decision. The reference model holds the old flags until the clock edge, so a decision made on the new flags is reported as a miscompare. The flags are then checked again on the next vector.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  typedef enum logic [3:0] {
    CC_ZS = 4'd0,  CC_ZC = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_NS = 4'd4,  CC_NC = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_HS = 4'd9,  CC_LO = 4'd10, CC_LS = 4'd11,
    CC_GT = 4'd12, CC_GE = 4'd13, CC_LT = 4'd14, CC_LE = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int NUM_COND = 16;

  function automatic logic cond_hit(input cond_e cc, input flags_t f);
    logic lt_s;
    lt_s = f.n ^ f.v;
    case (cc)
      CC_ZS:   return f.z;
      CC_ZC:   return !f.z;
      CC_CS:   return f.c;
      CC_CC:   return !f.c;
      CC_NS:   return f.n;
      CC_NC:   return !f.n;
      CC_VS:   return f.v;
      CC_VC:   return !f.v;
      CC_HI:   return !f.c && !f.z;
      CC_HS:   return !f.c;
      CC_LO:   return f.c;
      CC_LS:   return f.c || f.z;
      CC_GT:   return !lt_s && !f.z;
      CC_GE:   return !lt_s;
      CC_LT:   return lt_s;
      default: return lt_s || f.z;
    endcase
  endfunction

endpackage

// File: rtl/flag_alu.sv
module flag_alu
  import brcond_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output flags_t        nxt
);
  localparam int MSB = DW - 1;

  logic [DW:0]   ext;
  logic [DW-1:0] res;
  logic          sign_in_diff;
  logic          sign_flip;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
    res          = ext[DW-1:0];
    sign_in_diff = a[MSB] ^ b[MSB];
    sign_flip    = res[MSB] ^ a[MSB];
    nxt.c = ext[DW];
    nxt.n = res[MSB];
    nxt.z = (res == '0);
    nxt.v = sub ? (sign_in_diff && sign_flip) : (!sign_in_diff && sign_flip);
  end

  // R2: equal operands under subtract always give zero and no borrow
  always_comb begin
    p_eq_zero_r2: assert (!(sub && a == b) || (nxt.z && !nxt.c));
  end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import brcond_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end

  p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q));

  p_flags_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> q == $past(d));

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import brcond_pkg::*;
(
  input  flags_t f,
  input  cond_e  cc,
  output logic   hit
);
  logic [NUM_COND-1:0] hit_vec;

  for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
    assign hit_vec[i] = cond_hit(cond_e'(4'(i)), f);
  end

  assign hit = hit_vec[cc];

  always_comb begin
    p_pair_plain_r5: assert (hit_vec[0] != hit_vec[1] && hit_vec[2] != hit_vec[3] &&
                             hit_vec[4] != hit_vec[5] && hit_vec[6] != hit_vec[7]);
    p_pair_uns_r6:   assert (hit_vec[8] != hit_vec[11] && hit_vec[9] != hit_vec[10] &&
                             hit_vec[9] == hit_vec[3]);
    p_pair_sgn_r7:   assert (hit_vec[12] != hit_vec[15] && hit_vec[13] != hit_vec[14] &&
                             (!hit_vec[12] || hit_vec[13]));
  end

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_upd,
  input  logic          op_sub,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          br_valid,
  input  logic [3:0]    br_cond,
  input  logic [AW-1:0] pc_cur,
  input  logic [LW-1:0] instr_len,
  input  logic [AW-1:0] eff_addr,
  output logic          br_taken,
  output logic [AW-1:0] next_pc,
  output logic [3:0]    flags
);
  localparam int PAD = AW - LW;

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] pc, input logic [LW-1:0] len);
    return pc + {{PAD{1'b0}}, len};
  endfunction

  flags_t flags_nxt;
  flags_t flags_q;
  logic   cond_met;

  flag_alu #(.DW(DW)) u_alu (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (op_sub),
    .nxt (flags_nxt)
  );

  flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (flag_upd),
    .d     (flags_nxt),
    .q     (flags_q)
  );

  cond_eval u_eval (
    .f   (flags_q),
    .cc  (cond_e'(br_cond)),
    .hit (cond_met)
  );

  assign br_taken = br_valid && cond_met;
  assign next_pc  = br_taken ? eff_addr : seq_addr(pc_cur, instr_len);
  assign flags    = flags_q;

  p_taken_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> next_pc == eff_addr);

  p_idle_not_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> !br_taken);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> flags == 4'b0000);

endmodule

// File: tb/test_brcond_unit.sv
module test_brcond_unit;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flag_upd = 1'b0;
  logic          op_sub = 1'b0;
  logic [DW-1:0] opnd_a = '0;
  logic [DW-1:0] opnd_b = '0;
  logic          br_valid = 1'b0;
  logic [3:0]    br_cond = '0;
  logic [AW-1:0] pc_cur = '0;
  logic [LW-1:0] instr_len = '0;
  logic [AW-1:0] eff_addr = '0;
  logic          br_taken;
  logic [AW-1:0] next_pc;
  logic [3:0]    flags;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // reference flags
  bit mn = 0, mz = 0, mv = 0, mc = 0;

  brcond_unit #(.DW(DW), .AW(AW), .LW(LW)) i_brcond_unit (
    .clk(clk), .rst_n(rst_n), .flag_upd(flag_upd), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .br_valid(br_valid), .br_cond(br_cond),
    .pc_cur(pc_cur), .instr_len(instr_len), .eff_addr(eff_addr),
    .br_taken(br_taken), .next_pc(next_pc), .flags(flags)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(input int cc);
    bit lt;
    lt = mn != mv;
    case (cc)
      0: return mz;        1: return !mz;
      2: return mc;        3: return !mc;
      4: return mn;        5: return !mn;
      6: return mv;        7: return !mv;
      8: return !mc && !mz;
      9: return !mc;
      10: return mc;
      11: return mc || mz;
      12: return !lt && !mz;
      13: return !lt;
      14: return lt;
      default: return lt || mz;
    endcase
  endfunction

  function automatic int to_signed(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // one vector: drive at negedge, compare before next posedge, then advance model
  task automatic apply(input bit upd, input bit sub, input int a, input int b,
                       input bit bv, input int cc, input int pc, input int len, input int ea);
    bit exp_tk;
    int exp_pc;
    int s, res;
    string rq;
    @(negedge clk);
    flag_upd = upd; op_sub = sub; opnd_a = DW'(a); opnd_b = DW'(b);
    br_valid = bv; br_cond = 4'(cc); pc_cur = AW'(pc); instr_len = LW'(len); eff_addr = AW'(ea);
    #2;
    // R10: decision uses the flags held before this cycle's update
    exp_tk = bv && ref_hit(cc);
    exp_pc = exp_tk ? ea : ((pc + len) % 65536);
    rq = !bv ? "R9" : (cc < 8 ? "R5" : (cc < 12 ? "R6" : "R7"));
    if (upd && bv) rq = {rq, "/R10"};
    chk(rq, br_taken, exp_tk);
    chk("R8", next_pc, exp_pc);
    chk("R2/R3/R4 flags", flags, {mn, mz, mv, mc});
    @(posedge clk);
    #1;
    if (upd) begin
      if (sub) begin
        mc = a < b;
        s  = to_signed(a) - to_signed(b);
        res = (a - b) & 255;
      end else begin
        mc = (a + b) > 255;
        s  = to_signed(a) + to_signed(b);
        res = (a + b) & 255;
      end
      mv = (s > 127) || (s < -128);
      mn = res >= 128;
      mz = res == 0;
    end
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #2;
    chk("R1 flags", flags, 0);
    chk("R1 taken", br_taken, 0);
    chk("R1 next_pc", next_pc, 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(0, 0, 0, 0, 0, 0, 16'h0100, 2, 16'h2000);     // R1 after reset
    apply(0, 0, 0, 0, 1, 1, 16'h0100, 2, 16'h2000);     // Z=0 after reset: code 1 taken
    // R2: compare equal
    apply(1, 1, 8'h40, 8'h40, 0, 0, 16'h0200, 1, 16'h3000);
    for (int c = 0; c < 16; c++) apply(0, 0, 0, 0, 1, c, 16'h0300, 4, 16'h4000 + c);
    // R2/R6: unsigned lower, signed greater (5 - 200)
    apply(1, 1, 5, 200, 0, 0, 16'h0400, 2, 16'h0);
    for (int c = 0; c < 16; c++) apply(0, 0, 0, 0, 1, c, 16'h0410, 2, 16'h5000 + c);
    // R2/R7: signed overflow -128 - 1
    apply(1, 1, 8'h80, 8'h01, 0, 0, 16'h0500, 2, 16'h0);
    for (int c = 0; c < 16; c++) apply(0, 0, 0, 0, 1, c, 16'h0510, 3, 16'h6000 + c);
    // R3: add with carry-out and zero
    apply(1, 0, 8'hFF, 8'h01, 0, 0, 16'h0600, 2, 16'h0);
    for (int c = 0; c < 16; c++) apply(0, 0, 0, 0, 1, c, 16'h0610, 2, 16'h7000 + c);
    // R3: add with signed overflow 100 + 100
    apply(1, 0, 100, 100, 0, 0, 16'h0700, 2, 16'h0);
    for (int c = 0; c < 16; c++) apply(0, 0, 0, 0, 1, c, 16'h0710, 2, 16'h7100 + c);
    // R4: flags hold with operands changing but no update
    apply(0, 1, 3, 3, 0, 0, 16'h0800, 2, 16'h0);
    apply(0, 0, 8'hFF, 8'hFF, 1, 6, 16'h0800, 2, 16'h8000);
    // R10: update and branch together; decision must use old flags
    apply(1, 1, 7, 7, 1, 0, 16'h0900, 2, 16'h9000);
    apply(1, 1, 1, 2, 1, 0, 16'h0910, 2, 16'h9100);
    apply(0, 0, 0, 0, 1, 10, 16'h0920, 2, 16'h9200);
    // R8: sequential wrap
    apply(0, 0, 0, 0, 0, 10, 16'hFFFF, 2, 16'h1234);
    // R9: no request with a true condition
    apply(0, 0, 0, 0, 0, 2, 16'h0A00, 7, 16'hA000);
    // random mix
    for (int k = 0; k < 500; k++)
      apply($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 255),
            $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 15),
            $urandom_range(0, 65535), $urandom_range(0, 7), $urandom_range(0, 65535));
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule